// File: doc/BRIEF.md
# Vectored Interrupt Request Controller with Clear-by-Vector

This block collects interrupt requests from a parameterized set of external sources (32 by default). Each source carries its own detection mode (high level, low level, rising edge or falling edge), a priority level and a flag that routes its requests to a DMA engine instead of the CPU. Source inputs are synchronized, detected and latched into per-source pending flags. Among pending CPU-routed sources with a nonzero level, the one with the highest level (ties to the lowest index) is loaded into an 8-bit vector register. The register keeps that vector until software retires it.

Software retires a request by writing that source's vector number to a clear register on a simple synchronous register bus. The write removes the source's pending flag and also empties the vector register, so the retired source can no longer be identified. Pending DMA-routed sources are offered on a request/acknowledge pair. Once a DMA source has been taken, clear writes cannot remove it. Only the acknowledge can.

Top module: `irqv_ctrl`

## Requirements
- R1: Each source is detected according to its 2-bit mode field: 0 = input high, 1 = input low, 2 = rising edge, 3 = falling edge. A detected source becomes pending.
- R2: The vector of source index k is (k+1)*4, and the value 0 means nothing is held. When the vector register is 0, it loads the vector of the winning pending CPU-routed source. It then keeps that value until a clear write takes effect. It reads at bus address 0.
- R3: Among pending CPU-routed sources, the highest 3-bit level wins. On equal levels, the lowest index wins.
- R4: A source whose level is 0 never reaches the vector register or raises irq_o.
- R5: A bus write to address 1 whose bits 7:0 hold a valid source vector (bits 1:0 zero, index in range) removes that source's pending flag in any detection mode. The vector register reads 0 on the next cycle.
- R6: The clear register keeps bits 7:0 of the last write to address 1, resets to 0, and reads 0 in bits 31:8. A written value that names no source changes no pending flag and does not empty the vector register.
- R7: If a clear write and a new detection hit the same source in the same cycle, the source stays pending. This includes a level-mode input that is still active.
- R8: Pending sources with the DMA flag set are never presented to the CPU. The winner among them, chosen by the R3 rule, raises dma_req_o with its vector on dma_vec_o. Both hold steady until dma_ack_i, which retires the pending flag.
- R9: A clear write naming the source that dma_req_o is currently offering has no effect.
- R10: irq_o is high exactly when the vector register is nonzero.
- R11: After reset, the vector register, irq_o, dma_req_o, dma_vec_o and the clear register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw source inputs |
| mode_i | input | 2*NUM_SRC | Detection mode per source, 2 bits each |
| level_i | input | LVL_W*NUM_SRC | Priority level per source; 0 disables CPU requests |
| dma_en_i | input | NUM_SRC | Route source to DMA instead of CPU |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address (0 vector, 1 clear) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | CPU request, vector register nonzero |
| vec_o | output | 8 | Vector register |
| dma_req_o | output | 1 | DMA trigger held until acknowledge |
| dma_vec_o | output | 8 | Vector of the offered DMA source, 0 when idle |
| dma_ack_i | input | 1 | DMA transfer done for the offered source |

## Verification
A corrupted pending flag appears as a wrong or missing vector in the register within one cycle of the vector register emptying. That happens right after the next clear write, so a clear-and-reread loop over a random pending set exposes it within a few cycles. A wrong lock on the DMA side shows as dma_req_o dropping before acknowledge, or as a clear that silences it. Both are visible on the next cycle. Detection errors show up four cycles after the input changes, as a vector that never appears or appears without cause.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    DET_HIGH = 2'd0,
    DET_LOW  = 2'd1,
    DET_RISE = 2'd2,
    DET_FALL = 2'd3
  } det_mode_e;

  localparam int BUS_W     = 32;
  localparam int VEC_W     = 8;
  localparam int VEC_ADDR  = 0;
  localparam int CLR_ADDR  = 1;
endpackage

// File: rtl/irqv_detect.sv
module irqv_detect
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SRC-1:0]     src_i,
  input  logic [2*NUM_SRC-1:0]   mode_i,
  output logic [NUM_SRC-1:0]     hit_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic s1_q, s2_q, prev_q;
    det_mode_e mode;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= src_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign mode = det_mode_e'(mode_i[2*g +: 2]);

    always_comb begin
      unique case (mode)
        DET_HIGH: hit_o[g] = s2_q;
        DET_LOW:  hit_o[g] = ~s2_q;
        DET_RISE: hit_o[g] = s2_q & ~prev_q;
        DET_FALL: hit_o[g] = ~s2_q & prev_q;
        default:  hit_o[g] = 1'b0;
      endcase
    end

    // R1
    edge_no_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == DET_RISE && hit_o[g]) |-> !prev_q);
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [LVL_W*NUM_SRC-1:0] level_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o
);
  logic [LVL_W-1:0] best;

  // descending scan with >= lets the lower index take ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && level_i[LVL_W*i +: LVL_W] != '0 &&
          level_i[LVL_W*i +: LVL_W] >= best) begin
        valid_o = 1'b1;
        best    = level_i[LVL_W*i +: LVL_W];
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int LVL_W   = 3,
  parameter int ADDR_W  = 2,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic [2*NUM_SRC-1:0]     mode_i,
  input  logic [LVL_W*NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0]       dma_en_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [BUS_W-1:0]         bus_wdata_i,
  output logic [BUS_W-1:0]         bus_rdata_o,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic                     dma_req_o,
  output logic [VEC_W-1:0]         dma_vec_o,
  input  logic                     dma_ack_i
);
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return (VEC_W'(idx) + VEC_W'(1)) << 2;
  endfunction

  logic [NUM_SRC-1:0] hit, pend_q, pend_d, clr_mask, ack_mask;
  logic [VEC_W-1:0]   vec_q, vec_d, clr_q;
  logic               cpu_valid, dma_valid;
  logic [IDX_W-1:0]   cpu_idx, dma_win, dma_idx_q, clr_idx;
  logic               dma_busy_q;
  logic               clr_wr, clr_hit, clr_locked, clr_eff, dma_done;
  logic [5:0]         clr_num;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata_i[BUS_W-1:VEC_W];

  irqv_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .mode_i(mode_i),
    .hit_o (hit)
  );

  irqv_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_cpu_arb (
    .req_i  (pend_q & ~dma_en_i),
    .level_i(level_i),
    .valid_o(cpu_valid),
    .idx_o  (cpu_idx)
  );

  irqv_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_dma_arb (
    .req_i  (pend_q & dma_en_i),
    .level_i(level_i),
    .valid_o(dma_valid),
    .idx_o  (dma_win)
  );

  // clear-by-vector decode
  assign clr_wr     = bus_we_i && (bus_addr_i == ADDR_W'(CLR_ADDR));
  assign clr_num    = bus_wdata_i[7:2];
  assign clr_hit    = clr_wr && bus_wdata_i[1:0] == 2'b00 && clr_num != '0 &&
                      int'(clr_num) <= NUM_SRC;
  assign clr_idx    = IDX_W'(clr_num - 6'd1);
  assign clr_locked = dma_busy_q && (dma_idx_q == clr_idx);
  assign clr_eff    = clr_hit && !clr_locked;
  assign dma_done   = dma_busy_q && dma_ack_i;

  always_comb begin
    clr_mask = '0;
    ack_mask = '0;
    if (clr_eff)  clr_mask[clr_idx]   = 1'b1;
    if (dma_done) ack_mask[dma_idx_q] = 1'b1;
  end

  // a fresh detection overrides a same-cycle clear
  assign pend_d = (pend_q & ~clr_mask & ~ack_mask) | hit;

  always_comb begin
    vec_d = vec_q;
    if (clr_eff)                       vec_d = '0;
    else if (vec_q == '0 && cpu_valid) vec_d = vec_of(cpu_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      vec_q      <= '0;
      clr_q      <= '0;
      dma_busy_q <= 1'b0;
      dma_idx_q  <= '0;
    end else begin
      pend_q <= pend_d;
      vec_q  <= vec_d;
      if (clr_wr) clr_q <= bus_wdata_i[VEC_W-1:0];
      if (dma_done) begin
        dma_busy_q <= 1'b0;
      end else if (!dma_busy_q && dma_valid) begin
        dma_busy_q <= 1'b1;
        dma_idx_q  <= dma_win;
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(VEC_ADDR))      bus_rdata_o[VEC_W-1:0] = vec_q;
    else if (bus_addr_i == ADDR_W'(CLR_ADDR)) bus_rdata_o[VEC_W-1:0] = clr_q;
  end

  assign vec_o     = vec_q;
  assign irq_o     = vec_q != '0;
  assign dma_req_o = dma_busy_q;
  assign dma_vec_o = dma_busy_q ? vec_of(dma_idx_q) : '0;

  // R5
  clr_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_eff |=> vec_q == '0);
  // R2
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_q != '0 && !clr_eff) |=> $stable(vec_q));
  // R4
  level_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid |-> level_i[LVL_W*cpu_idx +: LVL_W] != '0);
  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));
  // R8
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_busy_q && !dma_ack_i) |=> (dma_busy_q && $stable(dma_idx_q)));
  // R9
  dma_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_busy_q && !dma_ack_i) |=> pend_q[dma_idx_q]);
endmodule

// File: tb/sim_irqv_ctrl.sv
module sim_irqv_ctrl;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [2*N-1:0] mode;
  logic [3*N-1:0] lvl;
  logic [N-1:0]  dma_en = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, dma_req, ack = 1'b0;
  logic [7:0]    vec, dma_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqv_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .mode_i(mode), .level_i(lvl),
    .dma_en_i(dma_en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq), .vec_o(vec), .dma_req_o(dma_req),
    .dma_vec_o(dma_vec), .dma_ack_i(ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; addr = 2'd0;
  endtask

  function automatic int vnum(input int k);
    return (k + 1) * 4;
  endfunction

  // expected winner: highest level, ties to lowest index, level 0 excluded
  function automatic int exp_vec(input logic [N-1:0] p, input logic [3*N-1:0] l);
    int best = 0, v = 0;
    for (int i = 0; i < N; i++)
      if (p[i] && int'(l[3*i +: 3]) > best) begin
        best = int'(l[3*i +: 3]); v = vnum(i);
      end
    return v;
  endfunction

  task automatic set_mode(input int k, input logic [1:0] m);
    mode[2*k +: 2] = m;
  endtask

  task automatic chk_vec(input string tag, input int e);
    chk(int'(vec) == e, tag, int'(vec), e);
    chk(irq == (e != 0), {tag, " R10 irq"}, int'(irq), int'(e != 0));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mode[2*i +: 2] = 2'd2;
      lvl[3*i +: 3]  = 3'd1;
    end
    void'($urandom(32'd4711));
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk_vec("R11 vec", 0);
    chk(dma_req == 1'b0 && dma_vec == 8'd0, "R11 dma", int'(dma_vec), 0);
    addr = 2'd1; #1;
    chk(rdata == 32'd0, "R11 clr reg", int'(rdata), 0);
    addr = 2'd0;

    // R1 high level, R7 level still active re-pends through clear
    set_mode(3, 2'd0); src[3] = 1'b1; cyc(5);
    chk_vec("R1 high", 16);
    bus_wr(2'd1, 32'd16);
    chk_vec("R5 wipe", 0);
    cyc(1);
    chk_vec("R7 level active", 16);
    src[3] = 1'b0; cyc(5);
    bus_wr(2'd1, 32'd16); cyc(3);
    chk_vec("R5 high cleared", 0);
    set_mode(3, 2'd2);

    // R1 low level
    set_mode(5, 2'd1); cyc(5);
    chk_vec("R1 low", 24);
    src[5] = 1'b1; cyc(5);
    bus_wr(2'd1, 32'd24); cyc(3);
    chk_vec("R5 low cleared", 0);
    set_mode(5, 2'd2); cyc(1); src[5] = 1'b0; cyc(4);

    // R1 falling edge
    set_mode(6, 2'd3); src[6] = 1'b1; cyc(5);
    chk_vec("R1 fall no rise", 0);
    src[6] = 1'b0; cyc(5);
    chk_vec("R1 fall", 28);
    bus_wr(2'd1, 32'd28); cyc(3);
    chk_vec("R5 fall cleared", 0);
    set_mode(6, 2'd2);

    // R4 level 0 never presented
    lvl[3*7 +: 3] = 3'd0; src[7] = 1'b1; cyc(5);
    chk_vec("R4 level zero", 0);
    src[7] = 1'b0;
    bus_wr(2'd1, 32'd32); lvl[3*7 +: 3] = 3'd1; cyc(3);
    chk_vec("R4 stays clear", 0);

    // R3 tie to lowest index
    lvl[3*9 +: 3] = 3'd5; lvl[3*4 +: 3] = 3'd5; lvl[3*2 +: 3] = 3'd4;
    src[9] = 1'b1; src[4] = 1'b1; src[2] = 1'b1; cyc(5);
    chk_vec("R3 tie", 20);
    src[9] = 1'b0; src[4] = 1'b0; src[2] = 1'b0;
    bus_wr(2'd1, 32'd20); cyc(1);
    chk_vec("R3 next", 40);
    bus_wr(2'd1, 32'd40); cyc(1);
    chk_vec("R3 last", 12);
    bus_wr(2'd1, 32'd12); cyc(3);
    chk_vec("R3 empty", 0);
    lvl[3*9 +: 3] = 3'd1; lvl[3*4 +: 3] = 3'd1; lvl[3*2 +: 3] = 3'd1;

    // R7 clear and new edge in the same cycle
    src[10] = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    we = 1'b1; addr = 2'd1; wdata = 32'd44;
    @(posedge clk); @(negedge clk);
    we = 1'b0; addr = 2'd0;
    chk_vec("R7 wipe same cycle", 0);
    @(posedge clk); @(negedge clk);
    chk_vec("R7 edge survives clear", 44);
    src[10] = 1'b0;
    bus_wr(2'd1, 32'd44); cyc(3);
    chk_vec("R7 cleanup", 0);

    // R6 clear register read back and invalid vector
    src[11] = 1'b1; cyc(5); src[11] = 1'b0;
    bus_wr(2'd1, 32'hABCD_EF77);
    addr = 2'd1; #1;
    chk(rdata == 32'h77, "R6 readback", int'(rdata), 32'h77);
    addr = 2'd0; cyc(2);
    chk_vec("R6 invalid ignored", 48);
    bus_wr(2'd1, 32'd48); cyc(2);

    // R8 DMA routing, R9 clear ignored while offered
    dma_en[12] = 1'b1; lvl[3*12 +: 3] = 3'd3; src[12] = 1'b1; cyc(5);
    src[12] = 1'b0;
    chk(dma_req == 1'b1, "R8 dma req", int'(dma_req), 1);
    chk(dma_vec == 8'd52, "R8 dma vec", int'(dma_vec), 52);
    chk_vec("R8 not to cpu", 0);
    bus_wr(2'd1, 32'd52); cyc(3);
    chk(dma_req == 1'b1 && dma_vec == 8'd52, "R9 clear ignored", int'(dma_vec), 52);
    ack = 1'b1; @(posedge clk); @(negedge clk); ack = 1'b0;
    chk(dma_req == 1'b0, "R8 ack drops", int'(dma_req), 0);
    cyc(3);
    chk(dma_req == 1'b0 && dma_vec == 8'd0, "R8 retired", int'(dma_vec), 0);
    dma_en[12] = 1'b0; lvl[3*12 +: 3] = 3'd1;

    // R2 R3 R5 random rounds, rising edge sources
    for (int r = 0; r < 20; r++) begin
      logic [N-1:0] m;
      int e;
      m = $urandom();
      for (int i = 0; i < N; i++) lvl[3*i +: 3] = 3'($urandom_range(7, 0));
      src = m; cyc(5); src = '0;
      for (int s = 0; s <= N; s++) begin
        e = exp_vec(m, lvl);
        chk_vec("R2 random vec", e);
        chk(rdata == 32'(e), "R2 bus vec", int'(rdata), e);
        if (e == 0) break;
        bus_wr(2'd1, 32'(e));
        chk_vec("R5 random wipe", 0);
        m[e/4 - 1] = 1'b0;
        cyc(1);
      end
      for (int i = 0; i < N; i++)
        if (m[i]) bus_wr(2'd1, 32'(vnum(i)));
      cyc(2);
      chk_vec("R4 random residue", 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule